// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block translates a 14-bit virtual address into a 12-bit physical address for a system with 64-byte pages. It caches 16 translations in four sets of four ways. A lookup selects one set with the two lowest bits of the virtual page number, compares every way of that set at once, and on a hit answers in the same cycle.

On a miss the block reads the page table through a read port. The port has a fixed latency of one cycle. A valid page table entry is installed in the selected set and the translation is returned. An entry that is not present is reported as a page fault and is not installed. A single-cycle flush input clears every cached translation.

The requester presents one address at a time. It watches `req_ready`, and `req_ready` is low while a page-table read is in progress. Each answered request carries one of three outcome codes, so a hit, a miss that was filled and a fault can be told apart.

Top module: `tlb_xlate`

## Requirements
- R1: A request that hits answers in the same cycle with `resp_valid`=1 and `resp_status`=2'b01. `resp_paddr` is {cached page number, `req_vaddr`[5:0]}: the 6-bit physical page number sits in bits 11..6 and the page offset passes through unchanged.
- R2: The virtual page number is `req_vaddr`[13:6]. Its bits 1..0 select the set, and its bits 7..2 form the tag that is compared against all four ways of that set. Pages that differ only in set bits never hit each other's entries. At most one way hits.
- R3: On a miss, `pt_rd_en` is high for one cycle in the cycle after the request, with `pt_rd_vpn` equal to the missed page number. The page table answers on `pt_rd_ppn`/`pt_rd_present` in the following cycle. If the entry is present, the response comes two cycles after the request with `resp_status`=2'b10 and `resp_paddr`={`pt_rd_ppn`, offset}, and the translation is installed so that a later request to that page hits.
- R4: If the page table entry is not present, the response two cycles after the request has `resp_status`=2'b11 and `resp_paddr`=0. Nothing is installed, so a repeat request faults again.
- R5: A fill goes to the lowest-numbered invalid way of its set. If the set is full, it goes to the way named by that set's round-robin pointer. Each pointer is 0 after reset and advances by one, wrapping from 3 to 0, each time it picks a way.
- R6: `flush` high at a clock edge clears every valid bit. A lookup in the flush cycle still sees the old contents, and a fill whose response cycle coincides with `flush` is returned but not installed.
- R7: While a page-table read is in progress `req_ready` is 0, and requests presented then are ignored: they give no response and cause no fill.
- R8: After reset no entry is valid, `req_ready`=1, `resp_valid`=0 and `pt_rd_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 14 | Virtual address to translate |
| req_ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | Response present this cycle |
| resp_status | output | 2 | 01 hit, 10 miss filled, 11 page fault |
| resp_paddr | output | 12 | Translated physical address |
| pt_rd_en | output | 1 | Page-table read strobe |
| pt_rd_vpn | output | 8 | Page number being read |
| pt_rd_ppn | input | 6 | Page-table frame number, one cycle after the strobe |
| pt_rd_present | input | 1 | Page-table entry present, one cycle after the strobe |

## Verification
Flush can coincide with a same-cycle hit, and it can also coincide with the response cycle of a fill. The bench raises `flush` in exactly the request cycle of a hit and then expects a hit answer followed by a miss on the same page. It also raises `flush` in the response cycle of a miss and expects a filled answer followed by another miss, because the install is dropped. A request held during a page-table read is judged by the latency and outcome of the walk in progress and by a later hit on the probed page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VA_W  = 14;
    parameter int PA_W  = 12;
    parameter int OFF_W = 6;
    parameter int SETS  = 4;
    parameter int WAYS  = 4;

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef enum logic [1:0] {
        ST_NONE  = 2'b00,
        ST_HIT   = 2'b01,
        ST_FILL  = 2'b10,
        ST_FAULT = 2'b11
    } resp_kind_e;

    typedef enum logic [1:0] {
        W_IDLE = 2'b00,
        W_READ = 2'b01,
        W_RESP = 2'b10
    } walk_e;
endpackage

// File: rtl/tlb_way_array.sv
module tlb_way_array
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [WAYS-1:0]  lk_valid,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PPN_W-1:0] wr_ppn
);
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]            vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0][PPN_W-1:0] ppn;
    } arr_t;

    arr_t            arr_q, arr_d;
    logic [WAYS-1:0] way_hit;

    // parallel compare of every way in the selected set
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = arr_q.vld[lk_set][w] && (arr_q.tag[lk_set][w] == lk_tag);
    end

    always_comb begin
        lk_ppn   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) lk_ppn = lk_ppn | arr_q.ppn[lk_set][w];
        end
        lk_hit   = |way_hit;
        lk_valid = arr_q.vld[lk_set];
    end

    always_comb begin
        arr_d = arr_q;
        if (flush) arr_d.vld = '0;
        if (wr_en) begin
            arr_d.vld[wr_set][wr_way] = 1'b1;
            arr_d.tag[wr_set][wr_way] = wr_tag;
            arr_d.ppn[wr_set][wr_way] = wr_ppn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arr_q <= '0;
        else        arr_q <= arr_d;
    end

    // R2: a tag is never held twice in one set
    a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    // R6: a flush leaves no valid entry behind (fills in that cycle are dropped upstream)
    a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (arr_q.vld == '0));
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] sel_set,
    input  logic [WAYS-1:0]  set_valid,
    input  logic             commit,
    output logic [WAY_W-1:0] victim
);
    logic [SETS-1:0][WAY_W-1:0] ptr_q, ptr_d;
    logic                       has_free;
    logic [WAY_W-1:0]           free_way;

    always_comb begin
        has_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_valid[w]) begin
                has_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
        victim = has_free ? free_way : ptr_q[sel_set];
        ptr_d  = ptr_q;
        if (commit && !has_free) ptr_d[sel_set] = ptr_q[sel_set] + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    output logic             resp_valid,
    output logic [1:0]       resp_status,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             pt_rd_en,
    output logic [VPN_W-1:0] pt_rd_vpn,
    input  logic [PPN_W-1:0] pt_rd_ppn,
    input  logic             pt_rd_present
);
    typedef struct packed {
        walk_e           state;
        logic [VA_W-1:0] va;
    } ctl_t;

    ctl_t             ctl_q, ctl_d;
    logic [VA_W-1:0]  lk_va;
    logic [IDX_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    logic             lk_hit;
    logic [PPN_W-1:0] lk_ppn;
    logic [WAYS-1:0]  lk_valid;
    logic             wr_en;
    logic [WAY_W-1:0] victim;

    always_comb begin
        lk_va  = (ctl_q.state == W_IDLE) ? req_vaddr : ctl_q.va;
        lk_set = lk_va[OFF_W +: IDX_W];
        lk_tag = lk_va[OFF_W + IDX_W +: TAG_W];
    end

    always_comb begin
        ctl_d       = ctl_q;
        resp_valid  = 1'b0;
        resp_status = ST_NONE;
        resp_paddr  = '0;
        wr_en       = 1'b0;
        case (ctl_q.state)
            W_IDLE: begin
                if (req_valid) begin
                    if (lk_hit) begin
                        resp_valid  = 1'b1;
                        resp_status = ST_HIT;
                        resp_paddr  = {lk_ppn, req_vaddr[OFF_W-1:0]};
                    end else begin
                        ctl_d.state = W_READ;
                        ctl_d.va    = req_vaddr;
                    end
                end
            end
            W_READ: ctl_d.state = W_RESP;
            W_RESP: begin
                resp_valid  = 1'b1;
                ctl_d.state = W_IDLE;
                if (pt_rd_present) begin
                    resp_status = ST_FILL;
                    resp_paddr  = {pt_rd_ppn, ctl_q.va[OFF_W-1:0]};
                    wr_en       = !flush;
                end else begin
                    resp_status = ST_FAULT;
                end
            end
            default: ctl_d.state = W_IDLE;
        endcase
        req_ready = (ctl_q.state == W_IDLE);
        pt_rd_en  = (ctl_q.state == W_READ);
        pt_rd_vpn = ctl_q.va[VA_W-1:OFF_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{state: W_IDLE, va: '0};
        else        ctl_q <= ctl_d;
    end

    tlb_way_array u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .lk_set   (lk_set),
        .lk_tag   (lk_tag),
        .lk_hit   (lk_hit),
        .lk_ppn   (lk_ppn),
        .lk_valid (lk_valid),
        .wr_en    (wr_en),
        .wr_set   (lk_set),
        .wr_way   (victim),
        .wr_tag   (lk_tag),
        .wr_ppn   (pt_rd_ppn)
    );

    tlb_victim_sel u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_set   (lk_set),
        .set_valid (lk_valid),
        .commit    (wr_en),
        .victim    (victim)
    );

    // R1: a hit keeps the page offset of the request
    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status == ST_HIT) |->
            (resp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]));

    // R3: a page-table read is answered by a fill or fault in the next cycle
    a_r3_walk_response: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_en |=> (resp_valid && resp_status != ST_HIT && resp_status != ST_NONE));

    // R7: no hit is answered while a walk is in progress
    a_r7_busy_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !(resp_valid && resp_status == ST_HIT));

    // R8: after a walk response the block is ready again
    a_r8_ready_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status != ST_HIT) |=> req_ready);
endmodule

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] K_HIT = 2'b01, K_FILL = 2'b10, K_FAULT = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [13:0] req_vaddr = '0;
    logic        req_ready, resp_valid, pt_rd_en;
    logic [1:0]  resp_status;
    logic [11:0] resp_paddr;
    logic [7:0]  pt_rd_vpn;
    logic [5:0]  pt_ppn_q = '0;
    logic        pt_present_q = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_status(resp_status), .resp_paddr(resp_paddr),
        .pt_rd_en(pt_rd_en), .pt_rd_vpn(pt_rd_vpn),
        .pt_rd_ppn(pt_ppn_q), .pt_rd_present(pt_present_q)
    );

    function automatic logic [5:0] ppn_of(input logic [7:0] vpn);
        return 6'(vpn * 7 + 3);
    endfunction

    function automatic logic present_of(input logic [7:0] vpn);
        return vpn[7:6] != 2'b11;
    endfunction

    // page-table model with one cycle of read latency
    always_ff @(posedge clk) begin
        if (pt_rd_en) begin
            pt_ppn_q     <= ppn_of(pt_rd_vpn);
            pt_present_q <= present_of(pt_rd_vpn);
        end
    end

    function automatic logic [15:0] mk(input logic [7:0] vpn, input logic [5:0] off,
                                       input logic [1:0] st);
        return {st, vpn, off};
    endfunction

    function automatic logic [11:0] exp_pa(input logic [13:0] va, input logic [1:0] st);
        return (st == K_FAULT) ? 12'h000 : {ppn_of(va[13:6]), va[5:0]};
    endfunction

    localparam int NV = 23;
    localparam logic [15:0] VEC [0:NV-1] = '{
        mk(8'h04, 6'h05, K_FILL),  mk(8'h04, 6'h3F, K_HIT),   mk(8'h08, 6'h00, K_FILL),
        mk(8'h0C, 6'h11, K_FILL),  mk(8'h10, 6'h22, K_FILL),  mk(8'h08, 6'h01, K_HIT),
        mk(8'h14, 6'h02, K_FILL),  mk(8'h04, 6'h03, K_FILL),  mk(8'h0C, 6'h04, K_HIT),
        mk(8'h08, 6'h05, K_FILL),  mk(8'h10, 6'h06, K_HIT),   mk(8'h05, 6'h07, K_FILL),
        mk(8'hC1, 6'h08, K_FAULT), mk(8'hC1, 6'h09, K_FAULT), mk(8'h05, 6'h0A, K_HIT),
        mk(8'h14, 6'h0B, K_HIT),   mk(8'h0C, 6'h0C, K_FILL),  mk(8'h14, 6'h0D, K_HIT),
        mk(8'h10, 6'h0E, K_FILL),  mk(8'h04, 6'h0F, K_HIT),   mk(8'hFF, 6'h10, K_FAULT),
        mk(8'h07, 6'h11, K_FILL),  mk(8'h07, 6'h12, K_HIT)
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // fl bit c raises flush in cycle c of the request (0 request, 1 read, 2 response)
    task automatic run_req(input logic [13:0] va, input logic [2:0] fl, input logic probe,
                           input logic [13:0] pv, output logic [1:0] st,
                           output logic [11:0] pa, output int lat);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        flush     = fl[0];
        st  = 2'b00;
        pa  = '0;
        lat = 7;
        for (int c = 0; c < 4; c++) begin
            #1;
            if (resp_valid) begin
                st  = resp_status;
                pa  = resp_paddr;
                lat = c;
                break;
            end
            @(negedge clk);
            req_valid = probe && (c == 0);
            req_vaddr = probe ? pv : va;
            flush     = (c < 2) ? fl[c + 1] : 1'b0;
        end
        @(negedge clk);
        req_valid = 1'b0;
        flush     = 1'b0;
    endtask

    task automatic expect_req(input string tag, input logic [13:0] va, input logic [2:0] fl,
                              input logic probe, input logic [13:0] pv, input logic [1:0] est);
        logic [1:0]  st;
        logic [11:0] pa;
        int          lat;
        run_req(va, fl, probe, pv, st, pa, lat);
        check(tag, {12'(lat), st, 4'h0, pa},
              {12'((est == K_HIT) ? 0 : 2), est, 4'h0, exp_pa(va, est)});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 ready after reset", 32'(req_ready), 32'd1);
        check("R8 no response after reset", 32'(resp_valid), 32'd0);
        check("R8 no page-table read after reset", 32'(pt_rd_en), 32'd0);

        // table walk: R1 hits, R2 set split, R3 fills, R4 faults, R5 victim order
        for (int i = 0; i < NV; i++) begin
            logic [1:0] est;
            est = VEC[i][15:14];
            expect_req((est == K_HIT) ? "R1 R2 hit" : (est == K_FILL) ? "R3 R5 fill" : "R4 fault",
                       VEC[i][13:0], 3'b000, 1'b0, 14'h0, est);
        end

        // R6: flush on its own clears everything
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        expect_req("R6 miss after flush", {8'h04, 6'h01}, 3'b000, 1'b0, 14'h0, K_FILL);
        // R6: lookup in the flush cycle sees old contents
        expect_req("R6 hit in flush cycle", {8'h04, 6'h02}, 3'b001, 1'b0, 14'h0, K_HIT);
        expect_req("R6 cleared by flush", {8'h04, 6'h03}, 3'b000, 1'b0, 14'h0, K_FILL);
        // R6: fill coinciding with flush is returned but not kept
        expect_req("R6 fill with flush", {8'h09, 6'h04}, 3'b100, 1'b0, 14'h0, K_FILL);
        expect_req("R6 dropped fill misses", {8'h09, 6'h05}, 3'b000, 1'b0, 14'h0, K_FILL);
        // R7: request held during a walk is ignored
        expect_req("R7 probe during walk", {8'h21, 6'h06}, 3'b000, 1'b1, {8'h09, 6'h07}, K_FILL);
        expect_req("R7 probed page still hits", {8'h09, 6'h08}, 3'b000, 1'b0, 14'h0, K_HIT);
        expect_req("R7 walked page hits", {8'h21, 6'h09}, 3'b000, 1'b0, 14'h0, K_HIT);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule